// File: doc/BRIEF.md
# Multi-port GPIO register bank

A memory-mapped general purpose I/O controller that groups its pins into 8-bit ports, by default seven of them. Each port owns a register window, and the windows repeat at a fixed byte stride. Inside a window, software finds the synchronised pad input levels, the output data, a two-bit drive mode for each pin and a pull-up disable mask. A single global control register reports how many ports are built in and which version of the block this is. Its two low bits enable the block clock request and the synchronisation select.

The block turns each pin's mode and data into pad-level controls: the output value, the output enable, an open-drain or open-source qualifier and a pull-up enable. Pins are numbered globally. Pin `8*p+n` is bit `n` of port `p` in every pad vector. The register bus is a plain single-cycle interface. A write takes effect at the clock edge where it is presented. Read data is combinational from the address while the access is enabled.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every register is zero: all pins are inputs with output enable 0 and output value 0, every pull-up is enabled, and both control outputs are 0.
- R2: The register at byte address 0x000 reads {16'b0, port count[6:0] in bits 15:9, version[6:0] in bits 8:2, bits 1:0}. Bit 0 is written to `clk_req` and bit 1 to `sync_sel`. Writes to bits 31:2 have no effect, and writing zero clears both outputs.
- R3: Port p owns the window starting at byte address p*0x30. Output data sits at +0x08 (bits 7:0), pin mode at +0x0C (bits 15:0) and pull-up disable at +0x10 (bits 7:0). All three are read/write, and their upper bits read as 0.
- R4: Pin n's mode is held in mode bits [2n+1:2n]. Code 00 (input) gives output enable 0, and code 01 (push-pull) gives output enable 1.
- R5: Code 10 (open-drain) sets `pad_od` and enables the driver only while the pin's output bit is 0. Code 11 (open-source) sets `pad_os` and enables the driver only while the output bit is 1. In every other mode both qualifiers are 0.
- R6: `pad_out` always equals the output data bit of the pin, whatever its mode.
- R7: `pad_pu_en` of a pin is the inverse of its pull-up disable bit, so a 1 in the register leaves the pin floating.
- R8: The input register at +0x04 returns `pad_in` through two flops. A pad change that is stable before edge k is read back from the cycle after edge k+1. Bits 31:8 read as 0, and writes to this register are ignored.
- R9: In every pad vector, bit 8*p+n belongs to port p, pin n.
- R10: Addresses that hold no register read as 0 and ignore writes. These are other offsets inside a window, offset 0 of any port other than port 0, unaligned addresses and addresses past the last window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access enable |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no access is enabled |
| clk_req | output | 1 | Block clock request enable |
| sync_sel | output | 1 | Synchronisation select enable |
| pad_in | input | 8*NUM_PORTS | Pad input levels |
| pad_out | output | 8*NUM_PORTS | Pad output values |
| pad_oe | output | 8*NUM_PORTS | Pad driver enables |
| pad_od | output | 8*NUM_PORTS | Open-drain qualifiers |
| pad_os | output | 8*NUM_PORTS | Open-source qualifiers |
| pad_pu_en | output | 8*NUM_PORTS | Pull-up enables |

## Verification
A pad input can change in the same cycle that software reads the input register, and a write to the output data can land while a pin sits in open-drain or open-source mode. In the second case the output enable moves together with the data. The bench changes `pad_in` on the very cycle it presents reads of the input register, and it rewrites output data under mixed modes. A behavioural model keeps the last two sampled pad values and the register contents. Every clock, the model predicts the read data and all pad controls, so a value one cycle early or late, or a missing enable flip, shows up as a mismatch.

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int NUM_PORTS  = 7,
  parameter int ADDR_W     = 9,
  parameter int STRIDE     = 48,
  parameter int VERSION_ID = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_en,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    clk_req,
  output logic                    sync_sel,
  input  logic [8*NUM_PORTS-1:0]  pad_in,
  output logic [8*NUM_PORTS-1:0]  pad_out,
  output logic [8*NUM_PORTS-1:0]  pad_oe,
  output logic [8*NUM_PORTS-1:0]  pad_od,
  output logic [8*NUM_PORTS-1:0]  pad_os,
  output logic [8*NUM_PORTS-1:0]  pad_pu_en
);
  localparam int PP     = 8;
  localparam int NPINS  = PP * NUM_PORTS;
  localparam int LIMIT  = NUM_PORTS * STRIDE;
  localparam int OFS_IN = 4, OFS_OUT = 8, OFS_MODE = 12, OFS_PUD = 16;
  localparam logic [6:0] CORES_F = 7'(NUM_PORTS);
  localparam logic [6:0] VER_F   = 7'(VERSION_ID);

  logic             wr;
  logic             ctrl_hit;
  logic [1:0]       ctrl_q;
  logic [NPINS-1:0] meta_q, sync_q;
  logic [PP-1:0]    out_q  [NUM_PORTS];
  logic [2*PP-1:0]  mode_q [NUM_PORTS];
  logic [PP-1:0]    pud_q  [NUM_PORTS];
  logic [31:0]      port_rd[NUM_PORTS];
  logic [31:0]      rd_all;
  logic             wdata_unused;

  assign wr           = bus_en && bus_we;
  assign ctrl_hit     = (bus_addr == '0);
  assign wdata_unused = ^bus_wdata[31:2*PP];
  assign clk_req      = ctrl_q[0];
  assign sync_sel     = ctrl_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              ctrl_q <= '0;
    else if (wr && ctrl_hit) ctrl_q <= bus_wdata[1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(p*STRIDE + OFS_IN);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(p*STRIDE + OFS_OUT);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(p*STRIDE + OFS_MODE);
    localparam logic [ADDR_W-1:0] A_PUD  = ADDR_W'(p*STRIDE + OFS_PUD);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        out_q[p]  <= '0;
        mode_q[p] <= '0;
        pud_q[p]  <= '0;
      end else if (wr) begin
        if (bus_addr == A_OUT)  out_q[p]  <= bus_wdata[PP-1:0];
        if (bus_addr == A_MODE) mode_q[p] <= bus_wdata[2*PP-1:0];
        if (bus_addr == A_PUD)  pud_q[p]  <= bus_wdata[PP-1:0];
      end

    assign port_rd[p] = (bus_addr == A_IN)   ? 32'(sync_q[p*PP +: PP]) :
                        (bus_addr == A_OUT)  ? 32'(out_q[p])  :
                        (bus_addr == A_MODE) ? 32'(mode_q[p]) :
                        (bus_addr == A_PUD)  ? 32'(pud_q[p])  : 32'd0;

    for (genvar n = 0; n < PP; n++) begin : g_pin
      logic [1:0] md;
      logic       ob;
      assign md = mode_q[p][2*n +: 2];
      assign ob = out_q[p][n];
      assign pad_out[p*PP+n]   = ob;
      assign pad_od[p*PP+n]    = (md == 2'b10);
      assign pad_os[p*PP+n]    = (md == 2'b11);
      assign pad_oe[p*PP+n]    = (md == 2'b01) || (md == 2'b10 && !ob) || (md == 2'b11 && ob);
      assign pad_pu_en[p*PP+n] = ~pud_q[p][n];

      AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_od[p*PP+n] && pad_oe[p*PP+n]) |-> !pad_out[p*PP+n]); // R5
      AST_OS_NEVER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_os[p*PP+n] && pad_oe[p*PP+n]) |-> pad_out[p*PP+n]); // R5
    end

    AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == A_OUT) |=> (pad_out[p*PP +: PP] == $past(bus_wdata[PP-1:0]))); // R3
    AST_PUD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == A_PUD) |=> (pad_pu_en[p*PP +: PP] == ~$past(bus_wdata[PP-1:0]))); // R7
  end

  always_comb begin
    rd_all = ctrl_hit ? {16'd0, CORES_F, VER_F, ctrl_q} : 32'd0;
    for (int p = 0; p < NUM_PORTS; p++) rd_all = rd_all | port_rd[p];
  end

  assign bus_rdata = bus_en ? rd_all : 32'd0;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;

  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (sync_q == $past(pad_in, 2))); // R8
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ctrl_hit) |=> (clk_req == $past(bus_wdata[0]) && sync_sel == $past(bus_wdata[1]))); // R2
  AST_IGNORE_FAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && int'(bus_addr) >= LIMIT) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_pu_en)
      && $stable(pad_od) && $stable(clk_req) && $stable(sync_sel))); // R10
endmodule

// File: tb/test_gpio_port_bank.sv
module test_gpio_port_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP  = 7;
  localparam int AW  = 9;
  localparam int STR = 48;
  localparam int VER = 5;
  localparam int NPN = 8 * NP;

  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic clk_req, sync_sel;
  logic [NPN-1:0] pad_in = '0, pad_out, pad_oe, pad_od, pad_os, pad_pu_en;

  int total = 0, bad = 0;
  bit done = 0;

  gpio_port_bank #(.NUM_PORTS(NP), .ADDR_W(AW), .STRIDE(STR), .VERSION_ID(VER)) i_gpio_port_bank (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_req(clk_req), .sync_sel(sync_sel),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_os(pad_os),
    .pad_pu_en(pad_pu_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  bit [1:0]  m_ctrl;
  bit [7:0]  m_out [NP];
  bit [15:0] m_mode[NP];
  bit [7:0]  m_pud [NP];
  bit [NPN-1:0] m_s1, m_s2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_s1 = 0; m_s2 = 0;
      for (int p = 0; p < NP; p++) begin m_out[p] = 0; m_mode[p] = 0; m_pud[p] = 0; end
    end else begin
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (bus_en && bus_we) begin
        int a, p, o;
        a = int'(bus_addr); p = a / STR; o = a % STR;
        if (a == 0) m_ctrl = bus_wdata[1:0];
        else if (a < NP*STR) begin
          if (o == 8)  m_out[p]  = bus_wdata[7:0];
          if (o == 12) m_mode[p] = bus_wdata[15:0];
          if (o == 16) m_pud[p]  = bus_wdata[7:0];
        end
      end
    end
  end

  function automatic bit [31:0] model_rd(int a);
    int p, o;
    p = a / STR; o = a % STR;
    if (!bus_en || a >= NP*STR) return 0;
    if (a == 0) return (NP << 9) | (VER << 2) | m_ctrl;
    case (o)
      4:  return 32'(m_s2[p*8 +: 8]);
      8:  return 32'(m_out[p]);
      12: return 32'(m_mode[p]);
      16: return 32'(m_pud[p]);
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(int a);
    int o;
    o = a % STR;
    if (!rst_n) return "R1";
    if (a == 0) return "R2";
    if (a >= NP*STR) return "R10";
    if (o == 4) return "R8";
    if (o == 8 || o == 12 || o == 16) return "R3";
    return "R10";
  endfunction

  task automatic check(bit ok, string tag, string what, logic [NPN-1:0] act, logic [NPN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    bit [NPN-1:0] e_out, e_oe, e_od, e_os, e_pu;
    bit [31:0] e_rd;
    string t;
    for (int p = 0; p < NP; p++)
      for (int n = 0; n < 8; n++) begin
        int k; bit o; bit [1:0] m;
        k = p*8 + n; o = m_out[p][n]; m = m_mode[p][2*n +: 2];
        e_out[k] = o;
        e_od[k]  = (m == 2);
        e_os[k]  = (m == 3);
        e_oe[k]  = (m == 1) ? 1'b1 : (m == 2) ? !o : (m == 3) ? o : 1'b0;
        e_pu[k]  = !m_pud[p][n];
      end
    e_rd = model_rd(int'(bus_addr));
    t = rst_n ? "" : "R1 ";
    check(pad_out === e_out, {t, "R6 R9"}, "pad_out", pad_out, e_out);
    check(pad_oe === e_oe, {t, "R4 R5"}, "pad_oe", pad_oe, e_oe);
    check(pad_od === e_od && pad_os === e_os, {t, "R5"}, "pad_od/os",
          pad_od ^ pad_os, e_od ^ e_os);
    check(pad_pu_en === e_pu, {t, "R7"}, "pad_pu_en", pad_pu_en, e_pu);
    check({sync_sel, clk_req} === m_ctrl, {t, "R2"}, "ctrl outs",
          NPN'({sync_sel, clk_req}), NPN'(m_ctrl));
    check(bus_rdata === e_rd, rd_tag(int'(bus_addr)), "bus_rdata", NPN'(bus_rdata), NPN'(e_rd));
  end

  task automatic wr(int a, bit [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); #2;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(int a, bit [31:0] exp, string tag);
    bus_en = 1; bus_we = 0; bus_addr = AW'(a);
    @(negedge clk);
    check(bus_rdata === exp, tag, "directed read", NPN'(bus_rdata), NPN'(exp));
    @(posedge clk); #2;
    bus_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pad_oe === '0 && pad_pu_en === '1 && !clk_req, "R1", "reset pads",
          pad_oe, '0);
    @(posedge clk); #2;
    rst_n = 1;
    @(posedge clk); #2;
    rd(0, (NP << 9) | (VER << 2), "R1 R2");
    wr(0, 32'hFFFF_FFFF);
    rd(0, (NP << 9) | (VER << 2) | 3, "R2");
    wr(0, 0);
    rd(0, (NP << 9) | (VER << 2), "R2");
    for (int p = 0; p < NP; p++) begin
      wr(p*STR + 8, 32'hFFFF_FF00 | (8'hA5 ^ p));
      wr(p*STR + 12, 32'hFFFF_E4E4 ^ (p << 2));
      wr(p*STR + 16, 32'h3C ^ p);
      rd(p*STR + 8, 32'(8'hA5 ^ p), "R3");
      rd(p*STR + 12, 32'(16'hE4E4 ^ (p << 2)), "R3");
    end
    wr(8, 32'h0);
    wr(12, 32'h0000_AAAA);
    @(negedge clk);
    check(pad_oe[7:0] === 8'hFF, "R5", "open-drain low drives", NPN'(pad_oe[7:0]), NPN'(8'hFF));
    @(posedge clk); #2;
    wr(8, 32'hFF);
    @(negedge clk);
    check(pad_oe[7:0] === 8'h00, "R5", "open-drain high released", NPN'(pad_oe[7:0]), 0);
    @(posedge clk); #2;
    wr(12, 32'h0000_FFFF);
    @(negedge clk);
    check(pad_oe[7:0] === 8'hFF && pad_os[7:0] === 8'hFF, "R5", "open-source high drives",
          NPN'(pad_oe[7:0]), NPN'(8'hFF));
    @(posedge clk); #2;
    wr(12, 32'h0);
    @(negedge clk);
    check(pad_oe[7:0] === 0 && pad_out[7:0] === 8'hFF, "R4 R6", "input mode keeps out",
          NPN'(pad_out[7:0]), NPN'(8'hFF));
    @(posedge clk); #2;
    pad_in = '0;
    repeat (3) @(posedge clk); #2;
    pad_in[15:8] = 8'h5A;
    rd(STR + 4, 0, "R8");
    rd(STR + 4, 0, "R8");
    rd(STR + 4, 32'h5A, "R8");
    wr(STR + 4, 32'hFF);
    rd(STR + 4, 32'h5A, "R8");
    wr(STR, 32'hFFFF_FFFF);
    wr(STR + 20, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    wr(NP*STR, 32'hFFFF_FFFF);
    wr(511, 32'hFFFF_FFFF);
    rd(STR, 0, "R10");
    rd(9, 0, "R10");
    rd(NP*STR, 0, "R10");
    rd(8, 32'hFF, "R10");
    for (int i = 0; i < 3000; i++) begin
      int sel, a;
      sel = $urandom_range(0, 9);
      a = $urandom_range(0, NP-1) * STR;
      case ($urandom_range(0, 7))
        0: a = a + 4;  1: a = a + 8;  2: a = a + 12; 3: a = a + 16;
        4: a = 0;      5: a = $urandom_range(0, 511);
        6: a = a + 9;  default: a = a + 8;
      endcase
      if (sel < 4) pad_in = {$urandom, $urandom};
      bus_en = ($urandom_range(0, 3) != 0);
      bus_we = $urandom_range(0, 1);
      bus_addr = AW'(a);
      bus_wdata = $urandom;
      @(posedge clk); #2;
    end
    bus_en = 0; bus_we = 0;
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule